// File: doc/BRIEF.md
# Bridge Control Lock and Interrupt Status Unit

This block holds the small set of control and status registers that sit beside a bus bridge. A 16-bit system control word drives the active-low reset of the downstream bus. The word carries a lock bit that guards it against stray writes, and only a fixed 16-bit key releases that lock. Event pulses from the surrounding logic set sticky bits in two status registers. The first is an 8-bit interrupt status register, cleared all at once by writing zero. The second is a 16-bit error status register whose top four bits are cleared one by one by writing ones.

An 8-bit mask picks which interrupt status bits may raise the interrupt line. A global enable bit must also be set before the line can assert at all. The registers are reached through a simple single-cycle write port and a combinational read port that share one word address.

Top module: `bridge_ctl_status`

## Requirements
- R1: `bus_rst_n` equals bit 15 of the system control word (address 0); 0 keeps the downstream bus in reset.
- R2: While the lock bit (bit 14 of the system word) is 1, a write of 0xA05F to address 0 clears only the lock bit and leaves bits 15 and 13..0 unchanged; every other write to address 0 leaves the word unchanged.
- R3: While unlocked, a write to address 0 stores all 16 bits, so a written bit 14 of 1 locks the word; the key value written while unlocked is stored like any other value.
- R4: Interrupt status (address 1, bits 7..0) bit n becomes 1 one cycle after `ist_evt_i[n]` is 1 and stays 1 until cleared. Bit meanings: 7 mailbox, 6 read abort, 5 write abort, 4 pin interrupt, 3 parity error, 2 inbound queue write, 1 DMA channel 1, 0 DMA channel 0.
- R5: Writing 0x00 to address 1 clears every interrupt status bit; writing a nonzero value there has no effect.
- R6: When an event and a clear hit the same status bit in one cycle, the bit ends up 1 (in both status registers).
- R7: Address 2 is an 8-bit read/write interrupt mask; bits 15..8 read 0.
- R8: `irq_o` is a register that, one cycle after the status, mask or enable changes, equals the enable bit (bit 0 of address 4) ANDed with the OR of status AND mask.
- R9: Error status (address 3) bits 15, 14, 13 and 12 (parity, system error, master abort, target abort) are set sticky by `err_evt_i[3]`, `[2]`, `[1]` and `[0]`; bits 11..0 read 0.
- R10: Writing to address 3 clears exactly the error bits written as 1; bits written as 0 keep their value.
- R11: After reset the system word is 0x0000 (unlocked, downstream reset asserted), both status registers, the mask and the enable are 0, and `irq_o` is 0.
- R12: Register map: 0 system, 1 interrupt status, 2 mask, 3 error status, 4 enable (bit 0 only); addresses 5 to 7 read 0 and ignore writes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| reg_we | input | 1 | Write strobe for the addressed register |
| reg_addr | input | 3 | Word address for write and read |
| reg_wdata | input | 16 | Write data |
| ist_evt_i | input | 8 | Interrupt event pulses, one per status bit |
| err_evt_i | input | 4 | Error event pulses (3 parity, 2 system, 1 master abort, 0 target abort) |
| reg_rdata | output | 16 | Read data of the addressed register, combinational |
| bus_rst_n | output | 1 | Downstream bus reset, active low |
| irq_o | output | 1 | Registered interrupt line |

## Verification
A register write or an event pulse shows up in the register contents, in `reg_rdata` and in `bus_rst_n` at the first rising edge after it is driven. `irq_o` carries one more register, so it follows one edge later. Each stimulus step therefore drives its inputs on a falling edge and then returns the port to idle on the next falling edge, pointing at the read address. The step samples 5 ns after the second rising edge, by which time both the register value and the interrupt line have settled. The reset checks wait for the two-stage internal reset release before any write.

// File: rtl/bcs_pkg.sv
package bcs_pkg;
  localparam int ADDR_W = 3;
  localparam int DATA_W = 16;
  localparam int IST_W  = 8;
  localparam int ERR_W  = 4;
  localparam int ERR_LSB = 12;

  localparam logic [ADDR_W-1:0] A_SYS  = 3'd0;
  localparam logic [ADDR_W-1:0] A_IST  = 3'd1;
  localparam logic [ADDR_W-1:0] A_MASK = 3'd2;
  localparam logic [ADDR_W-1:0] A_ERR  = 3'd3;
  localparam logic [ADDR_W-1:0] A_CFG  = 3'd4;

  localparam logic [DATA_W-1:0] UNLOCK_KEY = 16'hA05F;
  localparam int RUN_BIT  = 15;
  localparam int LOCK_BIT = 14;
  localparam int EN_BIT   = 0;

  typedef enum logic {CLR_ON_ZERO = 1'b0, CLR_W1C = 1'b1} clr_style_e;
endpackage

// File: rtl/bcs_sys_lock.sv
module bcs_sys_lock #(
  parameter int                W        = 16,
  parameter logic [W-1:0]      KEY      = 16'hA05F,
  parameter int                LOCK_POS = 14
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] word_q
);
  logic [W-1:0] word_d;
  logic         word_ce;
  logic         locked;

  assign locked = word_q[LOCK_POS];

  always_comb begin
    word_d  = word_q;
    word_ce = 1'b0;
    if (wr) begin
      if (!locked) begin
        word_d  = wdata;
        word_ce = 1'b1;
      end else if (wdata == KEY) begin
        word_d[LOCK_POS] = 1'b0;
        word_ce          = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       word_q <= '0;
    else if (word_ce) word_q <= word_d;
  end
endmodule

// File: rtl/bcs_sticky.sv
module bcs_sticky #(
  parameter int                  W     = 8,
  parameter bcs_pkg::clr_style_e STYLE = bcs_pkg::CLR_ON_ZERO
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] evt,
  input  logic         wr,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] q
);
  logic [W-1:0] clr;
  logic [W-1:0] q_d;
  logic         q_ce;

  generate
    if (STYLE == bcs_pkg::CLR_W1C) begin : g_w1c
      assign clr = wr ? wdata : '0;
    end else begin : g_zero
      assign clr = (wr && (wdata == '0)) ? '1 : '0;
    end
  endgenerate

  always_comb begin
    q_d  = (q & ~clr) | evt;
    q_ce = (|evt) || (|clr);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    q <= '0;
    else if (q_ce) q <= q_d;
  end
endmodule

// File: rtl/bcs_irq.sv
module bcs_irq #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] status,
  input  logic [W-1:0] mask,
  input  logic         enable,
  output logic         irq_q
);
  logic irq_d;

  always_comb irq_d = enable & (|(status & mask));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= irq_d;
  end
endmodule

// File: rtl/bridge_ctl_status.sv
module bridge_ctl_status
  import bcs_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  input  logic [IST_W-1:0]  ist_evt_i,
  input  logic [ERR_W-1:0]  err_evt_i,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              bus_rst_n,
  output logic              irq_o
);
  logic [1:0]        rst_sync_q;
  logic              rst_n_int;
  logic [DATA_W-1:0] sys_q;
  logic [IST_W-1:0]  ist_q;
  logic [IST_W-1:0]  mask_q;
  logic [IST_W-1:0]  mask_d;
  logic              mask_ce;
  logic [ERR_W-1:0]  err_q;
  logic              en_q;
  logic              en_d;
  logic              en_ce;
  logic              wr_sys, wr_ist, wr_mask, wr_err, wr_cfg;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_int = rst_sync_q[1];

  assign wr_sys  = reg_we && (reg_addr == A_SYS);
  assign wr_ist  = reg_we && (reg_addr == A_IST);
  assign wr_mask = reg_we && (reg_addr == A_MASK);
  assign wr_err  = reg_we && (reg_addr == A_ERR);
  assign wr_cfg  = reg_we && (reg_addr == A_CFG);

  bcs_sys_lock #(.W(DATA_W), .KEY(UNLOCK_KEY), .LOCK_POS(LOCK_BIT)) u_sys (
    .clk(clk), .rst_n(rst_n_int), .wr(wr_sys), .wdata(reg_wdata), .word_q(sys_q)
  );

  bcs_sticky #(.W(IST_W), .STYLE(CLR_ON_ZERO)) u_ist (
    .clk(clk), .rst_n(rst_n_int), .evt(ist_evt_i), .wr(wr_ist),
    .wdata(reg_wdata[IST_W-1:0]), .q(ist_q)
  );

  bcs_sticky #(.W(ERR_W), .STYLE(CLR_W1C)) u_err (
    .clk(clk), .rst_n(rst_n_int), .evt(err_evt_i), .wr(wr_err),
    .wdata(reg_wdata[ERR_LSB +: ERR_W]), .q(err_q)
  );

  always_comb begin
    mask_ce = wr_mask;
    mask_d  = reg_wdata[IST_W-1:0];
    en_ce   = wr_cfg;
    en_d    = reg_wdata[EN_BIT];
  end

  always_ff @(posedge clk or negedge rst_n_int) begin
    if (!rst_n_int) begin
      mask_q <= '0;
      en_q   <= 1'b0;
    end else begin
      if (mask_ce) mask_q <= mask_d;
      if (en_ce)   en_q   <= en_d;
    end
  end

  bcs_irq #(.W(IST_W)) u_irq (
    .clk(clk), .rst_n(rst_n_int), .status(ist_q), .mask(mask_q),
    .enable(en_q), .irq_q(irq_o)
  );

  assign bus_rst_n = sys_q[RUN_BIT];

  always_comb begin
    reg_rdata = '0;
    unique case (reg_addr)
      A_SYS:   reg_rdata = sys_q;
      A_IST:   reg_rdata[IST_W-1:0] = ist_q;
      A_MASK:  reg_rdata[IST_W-1:0] = mask_q;
      A_ERR:   reg_rdata[ERR_LSB +: ERR_W] = err_q;
      A_CFG:   reg_rdata[EN_BIT] = en_q;
      default: reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/bcs_checker.sv
module bcs_checker
  import bcs_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              reg_we,
  input logic [ADDR_W-1:0] reg_addr,
  input logic [DATA_W-1:0] reg_wdata,
  input logic [IST_W-1:0]  ist_evt_i,
  input logic [ERR_W-1:0]  err_evt_i,
  input logic [DATA_W-1:0] sys_q,
  input logic [IST_W-1:0]  ist_q,
  input logic [IST_W-1:0]  mask_q,
  input logic [ERR_W-1:0]  err_q,
  input logic              en_q,
  input logic              irq_o
);
  // R2: a locked word ignores non-key writes
  assert_locked_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (sys_q[LOCK_BIT] && reg_we && reg_addr == A_SYS && reg_wdata != UNLOCK_KEY)
      |=> $stable(sys_q));

  // R2: key releases only the lock bit
  assert_key_unlock_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (sys_q[LOCK_BIT] && reg_we && reg_addr == A_SYS && reg_wdata == UNLOCK_KEY)
      |=> (!sys_q[LOCK_BIT] && sys_q[RUN_BIT] == $past(sys_q[RUN_BIT])));

  // R4 / R6: an event always leaves its bit set
  assert_evt_sets_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (ist_evt_i != '0) |=> ((ist_q & $past(ist_evt_i)) == $past(ist_evt_i)));

  // R5: nonzero write does not clear anything
  assert_nonzero_keep_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_addr == A_IST && reg_wdata[IST_W-1:0] != '0)
      |=> ((ist_q & $past(ist_q)) == $past(ist_q)));

  // R10: written ones clear bits that see no event
  assert_w1c_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_addr == A_ERR && err_evt_i == '0)
      |=> ((err_q & $past(reg_wdata[ERR_LSB +: ERR_W])) == '0));

  // R8: no interrupt while disabled
  assert_irq_gated_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !en_q |=> !irq_o);

  // R8: enabled and pending raises the line next cycle
  assert_irq_raise_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q && (ist_q & mask_q) != '0) |=> irq_o);
endmodule

bind bridge_ctl_status bcs_checker u_chk (
  .clk(clk), .rst_n(rst_n_int), .reg_we(reg_we), .reg_addr(reg_addr),
  .reg_wdata(reg_wdata), .ist_evt_i(ist_evt_i), .err_evt_i(err_evt_i),
  .sys_q(sys_q), .ist_q(ist_q), .mask_q(mask_q), .err_q(err_q),
  .en_q(en_q), .irq_o(irq_o)
);

// File: tb/tb_bridge_ctl_status.sv
module tb_bridge_ctl_status;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        reg_we;
  logic [2:0]  reg_addr;
  logic [15:0] reg_wdata;
  logic [7:0]  ist_evt_i;
  logic [3:0]  err_evt_i;
  logic [15:0] reg_rdata;
  logic        bus_rst_n;
  logic        irq_o;

  int n_chk = 0;
  int n_bad = 0;

  always #10 clk = ~clk;   // 50 MHz

  bridge_ctl_status dut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .ist_evt_i(ist_evt_i), .err_evt_i(err_evt_i),
    .reg_rdata(reg_rdata), .bus_rst_n(bus_rst_n), .irq_o(irq_o)
  );

  typedef struct packed {
    logic        we;
    logic [2:0]  addr;
    logic [15:0] wdata;
    logic [7:0]  iev;
    logic [3:0]  eev;
    logic [2:0]  raddr;
    logic [15:0] exp_rd;
    logic        exp_irq;
    logic        exp_rstn;
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 17;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 3'd0, 16'h8001, 8'h00, 4'h0, 3'd0, 16'h8001, 1'b0, 1'b1, 8'd3},  // R3 R1 release bus
    '{1'b1, 3'd0, 16'hC002, 8'h00, 4'h0, 3'd0, 16'hC002, 1'b0, 1'b1, 8'd3},  // R3 lock
    '{1'b1, 3'd0, 16'h0000, 8'h00, 4'h0, 3'd0, 16'hC002, 1'b0, 1'b1, 8'd2},  // R2 ignored
    '{1'b1, 3'd0, 16'hA05F, 8'h00, 4'h0, 3'd0, 16'h8002, 1'b0, 1'b1, 8'd2},  // R2 key
    '{1'b1, 3'd0, 16'h0003, 8'h00, 4'h0, 3'd0, 16'h0003, 1'b0, 1'b0, 8'd1},  // R1 bus reset
    '{1'b0, 3'd0, 16'h0000, 8'h81, 4'h0, 3'd1, 16'h0081, 1'b0, 1'b0, 8'd4},  // R4 sticky
    '{1'b1, 3'd2, 16'h0001, 8'h00, 4'h0, 3'd2, 16'h0001, 1'b0, 1'b0, 8'd7},  // R7 mask
    '{1'b1, 3'd4, 16'h0001, 8'h00, 4'h0, 3'd4, 16'h0001, 1'b1, 1'b0, 8'd8},  // R8 enable
    '{1'b1, 3'd1, 16'h0005, 8'h00, 4'h0, 3'd1, 16'h0081, 1'b1, 1'b0, 8'd5},  // R5 nonzero
    '{1'b1, 3'd1, 16'h0000, 8'h04, 4'h0, 3'd1, 16'h0004, 1'b0, 1'b0, 8'd6},  // R6 R5
    '{1'b1, 3'd2, 16'h0004, 8'h00, 4'h0, 3'd2, 16'h0004, 1'b1, 1'b0, 8'd8},  // R8 mask
    '{1'b1, 3'd4, 16'h0000, 8'h00, 4'h0, 3'd4, 16'h0000, 1'b0, 1'b0, 8'd8},  // R8 gate
    '{1'b0, 3'd0, 16'h0000, 8'h00, 4'hA, 3'd3, 16'hA000, 1'b0, 1'b0, 8'd9},  // R9
    '{1'b1, 3'd3, 16'h2000, 8'h00, 4'h0, 3'd3, 16'h8000, 1'b0, 1'b0, 8'd10}, // R10
    '{1'b1, 3'd3, 16'h8000, 8'h00, 4'h8, 3'd3, 16'h8000, 1'b0, 1'b0, 8'd6},  // R6 err
    '{1'b1, 3'd3, 16'hFFFF, 8'h00, 4'h0, 3'd3, 16'h0000, 1'b0, 1'b0, 8'd10}, // R10 all
    '{1'b1, 3'd7, 16'hFFFF, 8'h00, 4'h0, 3'd7, 16'h0000, 1'b0, 1'b0, 8'd12}  // R12
  };

  task automatic check(input string what, input int req,
                       input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL R%0d %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic step(input logic we, input logic [2:0] addr, input logic [15:0] wd,
                      input logic [7:0] iev, input logic [3:0] eev, input logic [2:0] raddr);
    @(negedge clk);
    reg_we = we; reg_addr = addr; reg_wdata = wd; ist_evt_i = iev; err_evt_i = eev;
    @(negedge clk);
    reg_we = 1'b0; reg_addr = raddr; reg_wdata = '0; ist_evt_i = '0; err_evt_i = '0;
    @(posedge clk);
    #5;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(posedge clk);
    #5;
  endtask

  task automatic check_reset_state();
    for (int a = 0; a < 5; a++) begin
      reg_addr = a[2:0];
      #1;
      check("reset register value", 11, reg_rdata, 16'h0000);  // R11
    end
    check("reset irq", 11, {15'd0, irq_o}, 16'h0000);            // R11
    check("reset bus_rst_n", 11, {15'd0, bus_rst_n}, 16'h0000); // R11
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    reg_we = 1'b0; reg_addr = '0; reg_wdata = '0; ist_evt_i = '0; err_evt_i = '0;
    do_reset();
    check_reset_state();

    for (int i = 0; i < NV; i++) begin
      step(VECS[i].we, VECS[i].addr, VECS[i].wdata, VECS[i].iev, VECS[i].eev, VECS[i].raddr);
      check($sformatf("vector %0d rdata", i), int'(VECS[i].req), reg_rdata, VECS[i].exp_rd);
      check($sformatf("vector %0d irq", i), int'(VECS[i].req), {15'd0, irq_o}, {15'd0, VECS[i].exp_irq});
      check($sformatf("vector %0d bus_rst_n", i), int'(VECS[i].req), {15'd0, bus_rst_n}, {15'd0, VECS[i].exp_rstn});
    end

    // R3: key written while unlocked is an ordinary value, no lock
    step(1'b1, 3'd0, 16'hA05F, 8'h00, 4'h0, 3'd0);
    check("unlocked key stored", 3, reg_rdata, 16'hA05F);
    // R3: bit 14 alone locks and drops bit 15
    step(1'b1, 3'd0, 16'h4000, 8'h00, 4'h0, 3'd0);
    check("lock via bit 14", 3, reg_rdata, 16'h4000);
    check("bus reset after lock write", 1, {15'd0, bus_rst_n}, 16'h0000); // R1
    // R2: locked word refuses release of bus reset
    step(1'b1, 3'd0, 16'h8000, 8'h00, 4'h0, 3'd0);
    check("locked write ignored", 2, reg_rdata, 16'h4000);
    // R4: every interrupt bit sets independently
    step(1'b0, 3'd0, 16'h0000, 8'hFF, 4'h0, 3'd1);
    check("all interrupt bits set", 4, reg_rdata, 16'h00FF);
    // R7: upper bits of mask read 0
    step(1'b1, 3'd2, 16'hFF80, 8'h00, 4'h0, 3'd2);
    check("mask upper bits", 7, reg_rdata, 16'h0080);
    // R8: enable with mailbox bit pending raises irq
    step(1'b1, 3'd4, 16'h0001, 8'h00, 4'h0, 3'd4);
    check("irq from mailbox", 8, {15'd0, irq_o}, 16'h0001);
    // R5: zero write clears all, R8 irq falls one edge later
    step(1'b1, 3'd1, 16'h0000, 8'h00, 4'h0, 3'd1);
    check("zero write clears", 5, reg_rdata, 16'h0000);
    check("irq falls after clear", 8, {15'd0, irq_o}, 16'h0000);
    // R9: all error bits
    step(1'b0, 3'd0, 16'h0000, 8'h00, 4'hF, 3'd3);
    check("all error bits", 9, reg_rdata, 16'hF000);

    // R11: reset returns everything to idle values
    do_reset();
    check_reset_state();

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule